// File: doc/BRIEF.md
# Auto-Increment Register Bank Target on a Two-Wire Serial Bus

This block is a bus target for the standard two-wire serial bus (I2C). It holds a bank of eight 10-bit code registers that a bus controller can write and read back. The block oversamples SCL and SDA with a fast system clock. It recognises START and STOP conditions and compares the incoming address byte against a parameterised 7-bit device address. After a write address it takes a pointer byte and then pairs of data bytes. A register changes only when both bytes of its pair have arrived, and the pointer then steps to the next register, so one transaction can fill any consecutive run of registers. A read address streams back two bytes per register, starting at the current pointer.

The protocol engine is one state machine. ST_IDLE waits for START. ST_ADDR shifts in the address byte. ST_PTR takes the pointer byte. ST_DHI and ST_DLO take the upper and lower data bytes. ST_ACK pulls SDA low for the ninth clock and then moves on to the state it has stored. ST_RD_TX shifts a byte out. ST_RD_ACK samples the controller's acknowledge. ST_IGNORE waits out the rest of a rejected transaction.

The transitions are as follows. START from any state goes to ST_ADDR, and STOP from any state goes to ST_IDLE. A matching address goes to ST_ACK, followed by ST_PTR for a write or ST_RD_TX for a read. A foreign address goes to ST_IGNORE. A valid pointer goes through ST_ACK to ST_DHI, and an invalid one goes to ST_IGNORE. ST_DHI goes through ST_ACK to ST_DLO while registers remain, and otherwise to ST_IGNORE. ST_DLO commits and goes through ST_ACK back to ST_DHI. ST_RD_TX goes to ST_RD_ACK. ST_RD_ACK goes back to ST_RD_TX on an acknowledge and to ST_IGNORE on a not-acknowledge.

Top module: `i2c_rb_slave`

## Requirements
- R1: SDA falling while SCL is high is a START, and it restarts address reception from any state. SDA rising while SCL is high is a STOP, which returns the block to idle with SDA released. Both lines pass through a two-stage synchronizer first.
- R2: The first byte after START carries the 7-bit address, MSB first, followed by a direction bit (0 = write, 1 = read). A matching address is acknowledged: sda_oe is 1 during the ninth clock. A foreign address gets no acknowledge, and all later bytes are ignored until the next START.
- R3: In a write, the byte after the address is the pointer. Values 0x00 to 0x07 (bits 7:3 zero) are acknowledged and loaded into the pointer. Any other value is not acknowledged, the rest of the transaction is ignored, and no register changes.
- R4: Data arrives upper byte first. Only bits 1:0 of the upper byte are kept, as register bits 9:8. The lower byte supplies bits 7:0. Both bytes of every accepted pair are acknowledged.
- R5: A register, and its reg_upd bit, changes only on reception of the lower byte of its pair. reg_upd pulses for one clock in the same cycle that the new value appears on reg_q. At most one reg_upd bit is high at a time.
- R6: A STOP or a repeated START that arrives after the upper byte but before the lower byte leaves the addressed register and the pointer unchanged, and produces no strobe.
- R7: After each committed pair the pointer advances by one. Sixteen data bytes sent after pointer 0 write all eight registers in index order.
- R8: After the pair for register 7 commits, the pointer does not wrap. Every further data byte in that transaction is not acknowledged and changes nothing.
- R9: A read returns two bytes per register from the current pointer: first 000000 followed by bits 9:8, then bits 7:0. The pointer advances after each lower byte and keeps its value across transactions. Bytes past register 7 read 0x00. A controller not-acknowledge ends the read.
- R10: sda_oe (1 = pull SDA low) changes only while the synchronized SCL is low.
- R11: After reset all registers read zero, reg_upd is zero, sda_oe is zero and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| reg_q | output | NUM_REGS*REG_W | All register values, register i at bits i*REG_W upward |
| reg_upd | output | NUM_REGS | One-clock strobe per register on commit |

## Verification
The bench goes after the pairing rule. It ends transactions with a STOP and with a repeated START right after an upper byte. A design that committed half-pairs, or advanced its pointer on the upper byte, would corrupt the register or move the following write to a different register. It also runs a burst that starts near the top of the bank and overruns it, which catches a pointer that wraps to register 0 or keeps acknowledging. Foreign addresses and out-of-range pointers must leave every register and strobe count untouched. Reads check the zero-padded upper byte, that the pointer persists from a preceding write, and that bytes past the end read as zero.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_PTR,
        ST_DHI,
        ST_DLO,
        ST_ACK,
        ST_RD_TX,
        ST_RD_ACK,
        ST_IGNORE
    } rb_state_e;

endpackage

// File: rtl/i2c_rb_line_sync.sv
module i2c_rb_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic              scl_d;
    logic              sda_d;

    // Idle bus is high on both lines, so the chains reset to ones.
    generate
        if (STAGES == 1) begin : g_one
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= scl_i;
                    sda_ff <= sda_i;
                end
            end
        end else begin : g_many
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_ff <= '1;
                    sda_ff <= '1;
                end else begin
                    scl_ff <= {scl_ff[STAGES-2:0], scl_i};
                    sda_ff <= {sda_ff[STAGES-2:0], sda_i};
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_s;
            sda_d <= sda_s;
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_d;
    assign scl_fall  = ~scl_s & scl_d;
    // Line conditions qualified by SCL held high across both samples.
    assign start_det = scl_s & scl_d & sda_d & ~sda_s;
    assign stop_det  = scl_s & scl_d & ~sda_d & sda_s;

endmodule

// File: rtl/i2c_rb_regbank.sv
module i2c_rb_regbank #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 10,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [REG_W-1:0]          wr_data,
    output logic [NUM_REGS*REG_W-1:0] q_flat,
    output logic [NUM_REGS-1:0]       upd
);

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
            logic [REG_W-1:0] val_q;
            logic             upd_q;
            logic             hit;

            assign hit = wr_en && (wr_idx == IDX_W'(i));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= '0;
                    upd_q <= 1'b0;
                end else begin
                    upd_q <= hit;
                    if (hit) begin
                        val_q <= wr_data;
                    end
                end
            end

            assign q_flat[i*REG_W +: REG_W] = val_q;
            assign upd[i]                   = upd_q;
        end
    endgenerate

endmodule

// File: rtl/i2c_rb_txmux.sv
module i2c_rb_txmux #(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 10,
    localparam int PTR_W   = $clog2(NUM_REGS) + 1,
    localparam int HI_W    = REG_W - 8
) (
    input  logic [NUM_REGS*REG_W-1:0] q_flat,
    input  logic [PTR_W-1:0]          ptr,
    input  logic                      lo_sel,
    output logic [7:0]                tx_byte
);

    logic [7:0] hb;

    // Pointer values past the last register select nothing and read zero.
    always_comb begin
        tx_byte = '0;
        hb      = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (ptr == PTR_W'(i)) begin
                hb[HI_W-1:0] = q_flat[i*REG_W+8 +: HI_W];
                tx_byte      = lo_sel ? q_flat[i*REG_W +: 8] : hb;
            end
        end
    end

endmodule

// File: rtl/i2c_rb_slave.sv
module i2c_rb_slave
    import i2c_rb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h2C,
    parameter int         NUM_REGS = 8,
    parameter int         REG_W    = 10,
    parameter int         SYNC_N   = 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      scl_i,
    input  logic                      sda_i,
    output logic                      sda_oe,
    output logic [NUM_REGS*REG_W-1:0] reg_q,
    output logic [NUM_REGS-1:0]       reg_upd
);

    localparam int IDX_W = $clog2(NUM_REGS);
    localparam int PTR_W = IDX_W + 1;
    localparam int HI_W  = REG_W - 8;
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_rb_line_sync #(.STAGES(SYNC_N)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    rb_state_e        state, state_n;
    rb_state_e        nxt, nxt_n;
    logic [3:0]       cnt, cnt_n;
    logic [6:0]       sh, sh_n;
    logic [PTR_W-1:0] ptr, ptr_n;
    logic [HI_W-1:0]  hi_buf, hi_n;
    logic             rd_lo, rd_lo_n;
    logic             ack_ph, ack_ph_n;
    logic [7:0]       rx_byte;
    logic [7:0]       tx_byte;
    logic             wr_en;
    logic [REG_W-1:0] wr_data;

    assign rx_byte = {sh, sda_s};
    assign wr_data = {hi_buf, rx_byte};

    i2c_rb_regbank #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (ptr[IDX_W-1:0]),
        .wr_data (wr_data),
        .q_flat  (reg_q),
        .upd     (reg_upd)
    );

    i2c_rb_txmux #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_txmux (
        .q_flat  (reg_q),
        .ptr     (ptr),
        .lo_sel  (rd_lo),
        .tx_byte (tx_byte)
    );

    // Next-state and datapath decisions.
    always_comb begin
        state_n  = state;
        nxt_n    = nxt;
        cnt_n    = cnt;
        sh_n     = sh;
        ptr_n    = ptr;
        hi_n     = hi_buf;
        rd_lo_n  = rd_lo;
        ack_ph_n = ack_ph;
        wr_en    = 1'b0;

        if (start_det) begin
            state_n  = ST_ADDR;
            cnt_n    = '0;
            ack_ph_n = 1'b0;
        end else if (stop_det) begin
            state_n  = ST_IDLE;
            cnt_n    = '0;
            ack_ph_n = 1'b0;
        end else begin
            unique case (state)
                ST_IDLE, ST_IGNORE: begin
                end

                ST_ADDR, ST_PTR, ST_DHI, ST_DLO: begin
                    if (scl_rise) begin
                        sh_n  = rx_byte[6:0];
                        cnt_n = cnt + 4'd1;
                        if (cnt == 4'd7) begin
                            cnt_n    = '0;
                            ack_ph_n = 1'b0;
                            if (state == ST_ADDR) begin
                                if (rx_byte[7:1] == DEV_ADDR) begin
                                    state_n = ST_ACK;
                                    if (rx_byte[0]) begin
                                        nxt_n   = ST_RD_TX;
                                        rd_lo_n = 1'b0;
                                    end else begin
                                        nxt_n = ST_PTR;
                                    end
                                end else begin
                                    state_n = ST_IGNORE;
                                end
                            end else if (state == ST_PTR) begin
                                if (rx_byte < 8'(NUM_REGS)) begin
                                    ptr_n   = PTR_W'(rx_byte);
                                    state_n = ST_ACK;
                                    nxt_n   = ST_DHI;
                                end else begin
                                    state_n = ST_IGNORE;
                                end
                            end else if (state == ST_DHI) begin
                                if (ptr != PTR_END) begin
                                    hi_n    = rx_byte[HI_W-1:0];
                                    state_n = ST_ACK;
                                    nxt_n   = ST_DLO;
                                end else begin
                                    state_n = ST_IGNORE;
                                end
                            end else begin
                                wr_en   = 1'b1;
                                ptr_n   = ptr + PTR_W'(1);
                                state_n = ST_ACK;
                                nxt_n   = ST_DHI;
                            end
                        end
                    end
                end

                ST_ACK: begin
                    if (scl_fall) begin
                        if (!ack_ph) begin
                            ack_ph_n = 1'b1;
                        end else begin
                            ack_ph_n = 1'b0;
                            state_n  = nxt;
                            cnt_n    = '0;
                        end
                    end
                end

                ST_RD_TX: begin
                    if (scl_fall) begin
                        if (cnt == 4'd7) begin
                            cnt_n    = '0;
                            ack_ph_n = 1'b0;
                            state_n  = ST_RD_ACK;
                        end else begin
                            cnt_n = cnt + 4'd1;
                        end
                    end
                end

                ST_RD_ACK: begin
                    if (!ack_ph && scl_rise) begin
                        if (rd_lo && ptr != PTR_END) begin
                            ptr_n = ptr + PTR_W'(1);
                        end
                        rd_lo_n = ~rd_lo;
                        if (sda_s) begin
                            state_n = ST_IGNORE;
                        end else begin
                            ack_ph_n = 1'b1;
                        end
                    end else if (ack_ph && scl_fall) begin
                        ack_ph_n = 1'b0;
                        cnt_n    = '0;
                        state_n  = ST_RD_TX;
                    end
                end

                default: begin
                    state_n = ST_IDLE;
                end
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            nxt    <= ST_IDLE;
            cnt    <= '0;
            sh     <= '0;
            ptr    <= '0;
            hi_buf <= '0;
            rd_lo  <= 1'b0;
            ack_ph <= 1'b0;
        end else begin
            state  <= state_n;
            nxt    <= nxt_n;
            cnt    <= cnt_n;
            sh     <= sh_n;
            ptr    <= ptr_n;
            hi_buf <= hi_n;
            rd_lo  <= rd_lo_n;
            ack_ph <= ack_ph_n;
        end
    end

    // Outputs: SDA pull-down during the acknowledge phase or a low read bit.
    always_comb begin
        unique case (state)
            ST_ACK:   sda_oe = ack_ph;
            ST_RD_TX: sda_oe = ~tx_byte[3'd7 - cnt[2:0]];
            default:  sda_oe = 1'b0;
        endcase
    end

endmodule

// File: rtl/i2c_rb_chk.sv
module i2c_rb_chk
    import i2c_rb_pkg::*;
#(
    parameter int NUM_REGS = 8,
    parameter int REG_W    = 10
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      scl_s,
    input logic                      start_det,
    input logic                      stop_det,
    input rb_state_e                 state,
    input logic                      sda_oe,
    input logic [NUM_REGS*REG_W-1:0] reg_q,
    input logic [NUM_REGS-1:0]       reg_upd
);

    // R5
    upd_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_upd));

    // R5
    q_change_needs_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q != $past(reg_q)) |-> (reg_upd != '0));

    // R10
    sda_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_s);

    // R1
    start_to_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR));

    // R1
    stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

endmodule

bind i2c_rb_slave i2c_rb_chk #(.NUM_REGS(NUM_REGS), .REG_W(REG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .start_det (start_det),
    .stop_det  (stop_det),
    .state     (state),
    .sda_oe    (sda_oe),
    .reg_q     (reg_q),
    .reg_upd   (reg_upd)
);

// File: tb/tb_i2c_rb_slave.sv
module tb_i2c_rb_slave;

    localparam logic [6:0] DEV = 7'h2C;
    localparam int NR = 8;
    localparam int RW = 10;
    localparam int H  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic sda_i;
    logic sda_oe;
    logic [NR*RW-1:0] reg_q;
    logic [NR-1:0]    reg_upd;

    always #4 clk = ~clk;

    assign sda_i = sda_m & ~sda_oe;

    i2c_rb_slave #(.DEV_ADDR(DEV), .NUM_REGS(NR), .REG_W(RW)) dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_i   (scl_m),
        .sda_i   (sda_i),
        .sda_oe  (sda_oe),
        .reg_q   (reg_q),
        .reg_upd (reg_upd)
    );

    int total = 0;
    int bad = 0;
    bit done = 0;

    // Behavioural reference state.
    int m_reg [NR];
    int m_upd [NR];
    int o_upd [NR];
    int m_ptr = 0;
    int m_hi = 0;
    int mism = 0;
    int multi_upd = 0;
    int oe_hi_chg = 0;
    bit cmp_en = 0;
    logic prev_oe = 1'b0;
    logic [7:0] dq [$];

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Compared every clock while the bus rests.
    always @(negedge clk) begin
        if (rst_n) begin
            for (int i = 0; i < NR; i++) if (reg_upd[i]) o_upd[i]++;
            if ($countones(reg_upd) > 1) multi_upd++;
            if (sda_oe !== prev_oe && scl_m) oe_hi_chg++;
            if (cmp_en)
                for (int i = 0; i < NR; i++)
                    if (int'(reg_q[i*RW +: RW]) != m_reg[i]) mism++;
        end
        prev_oe = sda_oe;
    end

    task automatic bus_start();
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(5);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic wbyte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H);
            scl_m = 1'b1; wt(H);
            scl_m = 1'b0; wt(5);
        end
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H/2);
        ack = ~sda_i;
        wt(H/2);
        scl_m = 1'b0; wt(5);
    endtask

    task automatic rbyte(input bit mack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wt(H);
            scl_m = 1'b1; wt(H/2);
            b[i] = sda_i;
            wt(H/2);
            scl_m = 1'b0; wt(5);
        end
        sda_m = ~mack; wt(H);
        scl_m = 1'b1; wt(H);
        scl_m = 1'b0; wt(5);
        sda_m = 1'b1;
    endtask

    task automatic put(input logic [7:0] b);
        dq.push_back(b);
    endtask

    // Write transaction using queued data bytes; acks checked against model.
    task automatic wr_txn(input logic [6:0] a, input logic [7:0] p, input bit end_stop, input string req);
        bit ack;
        bit ok;
        cmp_en = 0;
        bus_start();
        ok = (a == DEV);
        wbyte({a, 1'b0}, ack);
        chk(ack == ok, {req, " addr ack"}, ack, ok);
        if (ok && p >= 8'(NR)) ok = 0;
        else if (ok) m_ptr = int'(p);
        wbyte(p, ack);
        chk(ack == ok, {req, " pointer ack"}, ack, ok);
        for (int k = 0; k < dq.size(); k++) begin
            bit exp;
            if (ok && (k % 2 == 0)) begin
                if (m_ptr >= NR) ok = 0;
                else m_hi = int'(dq[k]) & 3;
            end
            exp = ok;
            wbyte(dq[k], ack);
            chk(ack == exp, {req, " data ack"}, ack, exp);
            if (ok && (k % 2 == 1)) begin
                m_reg[m_ptr] = (m_hi << 8) | int'(dq[k]);
                m_upd[m_ptr]++;
                m_ptr++;
            end
        end
        dq.delete();
        if (end_stop) begin
            bus_stop();
            wt(10);
            cmp_en = 1;
        end
    endtask

    task automatic rd_txn(input int n, input string req);
        bit ack;
        logic [7:0] b;
        int exp;
        bit lo = 0;
        cmp_en = 0;
        bus_start();
        wbyte({DEV, 1'b1}, ack);
        chk(ack == 1'b1, {req, " read addr ack"}, ack, 1);
        for (int k = 0; k < n; k++) begin
            rbyte(k < n - 1, b);
            if (m_ptr >= NR) exp = 0;
            else exp = lo ? (m_reg[m_ptr] & 8'hFF) : (m_reg[m_ptr] >> 8);
            chk(int'(b) == exp, {req, " read byte"}, b, exp);
            if (lo && m_ptr < NR) m_ptr++;
            lo = ~lo;
        end
        bus_stop();
        wt(10);
        cmp_en = 1;
    endtask

    task automatic chk_regs(input string req);
        for (int i = 0; i < NR; i++) begin
            chk(int'(reg_q[i*RW +: RW]) == m_reg[i], {req, " register value"}, reg_q[i*RW +: RW], m_reg[i]);
            chk(o_upd[i] == m_upd[i], {req, " strobe count"}, o_upd[i], m_upd[i]);
        end
        chk(mism == 0, {req, " per-clock compare"}, mism, 0);
        // R1: bus released after STOP
        chk(sda_oe == 1'b0, "R1 sda released after stop", sda_oe, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NR; i++) begin
            m_reg[i] = 0; m_upd[i] = 0; o_upd[i] = 0;
        end
        wt(5);
        // R11: reset state
        chk(reg_q == '0, "R11 registers zero", 0, 0);
        chk(reg_upd == '0, "R11 strobes zero", reg_upd, 0);
        chk(sda_oe == 1'b0, "R11 sda released", sda_oe, 0);
        rst_n = 1'b1;
        wt(10);
        cmp_en = 1;

        // R4 R5: single pair, upper byte keeps only bits 1:0
        put(8'hFE); put(8'h5A);
        wr_txn(DEV, 8'h03, 1, "R4");
        chk(reg_q[3*RW +: RW] == 10'h25A, "R4 reg3 value", reg_q[3*RW +: RW], 10'h25A);
        chk_regs("R5");

        // R7: burst of 16 bytes from pointer 0
        for (int i = 0; i < NR; i++) begin
            put(8'(8'h10 + i * 8'h05)); put(8'(8'hA0 + i));
        end
        wr_txn(DEV, 8'h00, 1, "R7");
        chk_regs("R7");

        // R2: foreign address ignored
        put(8'h11); put(8'h22);
        wr_txn(DEV ^ 7'h01, 8'h00, 1, "R2");
        chk_regs("R2");

        // R3: out-of-range pointers rejected
        put(8'h01); put(8'h02);
        wr_txn(DEV, 8'h08, 1, "R3");
        put(8'h01); put(8'h02);
        wr_txn(DEV, 8'h13, 1, "R3");
        chk_regs("R3");

        // R6: STOP after upper byte
        put(8'h03);
        wr_txn(DEV, 8'h05, 1, "R6");
        chk_regs("R6 stop");

        // R6: repeated START after upper byte, then a full pair elsewhere
        put(8'h02);
        wr_txn(DEV, 8'h01, 0, "R6");
        put(8'h01); put(8'h77);
        wr_txn(DEV, 8'h04, 1, "R6");
        chk(reg_q[4*RW +: RW] == 10'h177, "R6 reg4 after restart", reg_q[4*RW +: RW], 10'h177);
        chk_regs("R6 restart");

        // R8: overrun past register 7
        put(8'h02); put(8'h33); put(8'h01); put(8'h44); put(8'h03); put(8'h55);
        wr_txn(DEV, 8'h06, 1, "R8");
        chk_regs("R8");

        // R9: set pointer, repeated START, read back; pointer persists
        wr_txn(DEV, 8'h02, 0, "R9");
        rd_txn(4, "R9");
        rd_txn(2, "R9");
        wr_txn(DEV, 8'h07, 0, "R9");
        rd_txn(4, "R9");
        chk_regs("R9");

        // R10 R5: line and strobe discipline over the whole run
        chk(oe_hi_chg == 0, "R10 sda_oe changed with SCL high", oe_hi_chg, 0);
        chk(multi_upd == 0, "R5 more than one strobe", multi_upd, 0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule